// File: doc/BRIEF.md
# Predicated Dual-Issue Execute Stage

This block is the execute and write-back stage of a statically scheduled two-wide processor. Each cycle it accepts one bundle of two 32-bit integer operations and runs both in parallel. It holds a 16-entry general-purpose register file of 32-bit words and an 8-entry file of one-bit guards. Every operation names one guard. A compare writes a pair of guards with the outcome and its inverse, so that the two arms of an if/else can share one bundle. An operation whose guard is false leaves no trace in either register file.

Two conditional moves turn a short if/else into a data operation. One copies its source when a test register is zero, and the other copies it when the test register is non-zero. Branches ignore their guard and always evaluate their own condition. The chosen target is reported one cycle later. Both register files are visible at the ports so that the surrounding pipeline, or a bench, can observe the architectural state.

Instruction word layout: opcode [31:28], guard index [27:25], destination [24:21], first source [20:17], second source / test register [16:13], immediate [12:0] (two's complement, sign-extended to 32 bits).

Top module: `vpx_exec`

## Requirements
- R1: While `rst` is high at a rising edge, every general-purpose register becomes zero, guard 0 becomes 1, guards 1 to 7 become 0, and `br_taken` and `br_target` become 0.
- R2: With a true guard, opcodes 1 ADD, 2 SUB, 3 AND, 4 OR and 5 XOR write rd with rs op rt, and opcode 6 ADDI writes rd with rs plus the sign-extended immediate. The result is visible on `gpr_view` (register n at bits [32n+31:32n]) after the next rising edge. Opcode 0 changes nothing.
- R3: General-purpose register 0 always reads as zero, and any write to it is dropped.
- R4: Opcode 7, move-if-zero, copies rs into rd only when rt equals zero. Otherwise both files are unchanged.
- R5: Opcode 8, move-if-nonzero, copies rs into rd only when rt is non-zero. Otherwise both files are unchanged.
- R6: Opcodes 9 (equal), 10 (signed less-than) and 11 (unsigned less-than) compare rs with rt. They write the result into the guard indexed by rd[2:0] and its inverse into the guard indexed by imm[2:0]. If both indices are the same, the direct result wins. Guard 0 stays 1 whatever is written to it. Guards appear on `pred_view` at bit n.
- R7: When the guard named by an operation is 0, that operation writes no general-purpose register and no guard.
- R8: Both slots read their sources from the state held before the bundle, so two operations in one bundle can swap two registers.
- R9: When both slots write the same destination in one bundle, the value from slot 1 remains. This holds for general-purpose registers and for guards, in the order slot 0 inverse, slot 0 result, slot 1 inverse, slot 1 result.
- R10: A guard written by a bundle takes effect for operations of the next bundle, not for the other operation of the same bundle.
- R11: Opcodes 12 (branch if rs equals rt) and 13 (branch if rs differs from rt) ignore their guard. After the next edge, `br_taken` shows whether either was taken and `br_target` shows `bundle_pc` plus the sign-extended immediate of the taken branch. Slot 0 has priority when both are taken.
- R12: When `bundle_valid` is low, neither file changes and `br_taken` is 0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bundle_valid | input | 1 | A bundle is present this cycle |
| bundle_pc | input | 32 | Address of the bundle, base for branch targets |
| insn0 | input | 32 | Operation for slot 0 |
| insn1 | input | 32 | Operation for slot 1 |
| br_taken | output | 1 | A branch of the previous bundle was taken |
| br_target | output | 32 | Target of that branch |
| gpr_view | output | 512 | All general-purpose registers, register n at [32n+31:32n] |
| pred_view | output | 8 | All guard bits, guard n at bit n |

## Verification
The bench pairs a guard set by a compare with a consumer in the same bundle. A design that forwarded the new guard would write a register that must stay untouched. It tests each conditional move with both a zero and a non-zero test register, so an inverted test shows up as a stray or missing copy. It sends swaps and same-destination pairs, where wrong read timing corrupts both registers and a wrong priority leaves the slot 0 value. It also sends branches under false guards and two taken branches at once, which catches a design that predicates branches or lets slot 1 take priority. After each bundle both files are compared in full with a reference model, which also catches writes to register 0 or guard 0 and state that changes while no bundle is valid.

// File: rtl/vpx_pkg.sv
package vpx_pkg;
    localparam int XLEN  = 32;
    localparam int NGPR  = 16;
    localparam int NPRED = 8;
    localparam int NSLOT = 2;
    localparam int GW    = $clog2(NGPR);
    localparam int PW    = $clog2(NPRED);
    localparam int IMMW  = XLEN - 4 - PW - 3 * GW;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_ADD   = 4'd1,
        OP_SUB   = 4'd2,
        OP_AND   = 4'd3,
        OP_OR    = 4'd4,
        OP_XOR   = 4'd5,
        OP_ADDI  = 4'd6,
        OP_MOVZ  = 4'd7,
        OP_MOVN  = 4'd8,
        OP_CMPEQ = 4'd9,
        OP_CMPLT = 4'd10,
        OP_CMPLTU= 4'd11,
        OP_BEQ   = 4'd12,
        OP_BNE   = 4'd13
    } op_e;

    typedef struct packed {
        op_e              op;
        logic [PW-1:0]    guard;
        logic [GW-1:0]    rd;
        logic [GW-1:0]    rs;
        logic [GW-1:0]    rt;
        logic [IMMW-1:0]  imm;
    } insn_t;

    typedef struct packed {
        logic             gpr_we;
        logic [GW-1:0]    gpr_wa;
        logic [XLEN-1:0]  gpr_wd;
        logic             pt_we;
        logic [PW-1:0]    pt_wa;
        logic             pf_we;
        logic [PW-1:0]    pf_wa;
        logic             pval;
        logic             br_take;
        logic [XLEN-1:0]  br_tgt;
    } slot_res_t;

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMMW-1:0] i);
        return {{(XLEN-IMMW){i[IMMW-1]}}, i};
    endfunction

    function automatic logic is_branch(input op_e op);
        return (op == OP_BEQ) || (op == OP_BNE);
    endfunction
endpackage

// File: rtl/vpx_gpr_file.sv
module vpx_gpr_file
    import vpx_pkg::*;
#(
    parameter int DEPTH = NGPR,
    parameter int WIDTH = XLEN,
    parameter int NRD   = 2 * NSLOT,
    parameter int NWR   = NSLOT,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [AW-1:0]          rd_addr [NRD],
    output logic [WIDTH-1:0]       rd_data [NRD],
    input  logic                   we      [NWR],
    input  logic [AW-1:0]          wa      [NWR],
    input  logic [WIDTH-1:0]       wd      [NWR],
    output logic [DEPTH*WIDTH-1:0] view
);
    logic [WIDTH-1:0] regs [DEPTH];

    generate
        for (genvar r = 0; r < NRD; r++) begin : g_rd
            assign rd_data[r] = regs[rd_addr[r]];
        end
        for (genvar e = 0; e < DEPTH; e++) begin : g_view
            assign view[e*WIDTH +: WIDTH] = regs[e];
        end
    endgenerate

    // Later ports override earlier ones: slot 1 wins on collision.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < DEPTH; e++) regs[e] <= '0;
        end else begin
            for (int w = 0; w < NWR; w++) begin
                if (we[w] && wa[w] != '0) regs[wa[w]] <= wd[w];
            end
        end
    end

    p_zero_reg_r3: assert property (@(posedge clk) disable iff (rst)
        regs[0] == '0);

    p_last_slot_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (we[0] && we[NWR-1] && wa[0] == wa[NWR-1] && wa[NWR-1] != '0)
        |=> regs[$past(wa[NWR-1])] == $past(wd[NWR-1]));
endmodule

// File: rtl/vpx_pred_file.sv
module vpx_pred_file
    import vpx_pkg::*;
#(
    parameter int DEPTH = NPRED,
    parameter int NRD   = NSLOT,
    parameter int NWR   = 2 * NSLOT,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    rd_addr [NRD],
    output logic             rd_data [NRD],
    input  logic             we      [NWR],
    input  logic [AW-1:0]    wa      [NWR],
    input  logic             wd      [NWR],
    output logic [DEPTH-1:0] view
);
    logic [DEPTH-1:0] bits_q;

    generate
        for (genvar r = 0; r < NRD; r++) begin : g_rd
            assign rd_data[r] = bits_q[rd_addr[r]];
        end
    endgenerate
    assign view = bits_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q <= {{(DEPTH-1){1'b0}}, 1'b1};
        end else begin
            for (int w = 0; w < NWR; w++) begin
                if (we[w] && wa[w] != '0) bits_q[wa[w]] <= wd[w];
            end
        end
    end

    p_guard0_true_r6: assert property (@(posedge clk) disable iff (rst)
        bits_q[0] == 1'b1);

    p_no_write_holds_r12: assert property (@(posedge clk) disable iff (rst)
        (we[0] == 1'b0 && we[1] == 1'b0 && we[2] == 1'b0 && we[3] == 1'b0)
        |=> $stable(bits_q));
endmodule

// File: rtl/vpx_slot.sv
module vpx_slot
    import vpx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    input  insn_t            insn,
    input  logic [XLEN-1:0]  rs_val,
    input  logic [XLEN-1:0]  rt_val,
    input  logic [XLEN-1:0]  pc,
    input  logic             guard,
    output slot_res_t        res
);
    logic            en;
    logic            cmp;
    logic [XLEN-1:0] alu;

    assign en = valid && guard;

    always_comb begin
        unique case (insn.op)
            OP_CMPEQ:  cmp = (rs_val == rt_val);
            OP_CMPLT:  cmp = ($signed(rs_val) < $signed(rt_val));
            OP_CMPLTU: cmp = (rs_val < rt_val);
            OP_BEQ:    cmp = (rs_val == rt_val);
            OP_BNE:    cmp = (rs_val != rt_val);
            default:   cmp = 1'b0;
        endcase
    end

    always_comb begin
        unique case (insn.op)
            OP_ADD:  alu = rs_val + rt_val;
            OP_SUB:  alu = rs_val - rt_val;
            OP_AND:  alu = rs_val & rt_val;
            OP_OR:   alu = rs_val | rt_val;
            OP_XOR:  alu = rs_val ^ rt_val;
            OP_ADDI: alu = rs_val + sext_imm(insn.imm);
            default: alu = rs_val;
        endcase
    end

    always_comb begin
        res         = '0;
        res.gpr_wa  = insn.rd;
        res.gpr_wd  = alu;
        res.pt_wa   = insn.rd[PW-1:0];
        res.pf_wa   = insn.imm[PW-1:0];
        res.pval    = cmp;
        res.br_tgt  = pc + sext_imm(insn.imm);
        unique case (insn.op)
            OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_ADDI:
                res.gpr_we = en;
            OP_MOVZ:
                res.gpr_we = en && (rt_val == '0);
            OP_MOVN:
                res.gpr_we = en && (rt_val != '0);
            OP_CMPEQ, OP_CMPLT, OP_CMPLTU: begin
                res.pt_we = en;
                res.pf_we = en;
            end
            OP_BEQ, OP_BNE:
                res.br_take = valid && cmp;
            default: ;
        endcase
    end

    p_nullified_r7: assert property (@(posedge clk) disable iff (rst)
        (valid && !guard) |-> (!res.gpr_we && !res.pt_we && !res.pf_we));

    p_movz_gate_r4: assert property (@(posedge clk) disable iff (rst)
        (insn.op == OP_MOVZ && rt_val != '0) |-> !res.gpr_we);

    p_movn_gate_r5: assert property (@(posedge clk) disable iff (rst)
        (insn.op == OP_MOVN && rt_val == '0) |-> !res.gpr_we);
endmodule

// File: rtl/vpx_exec.sv
module vpx_exec
    import vpx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bundle_valid,
    input  logic [31:0]          bundle_pc,
    input  logic [31:0]          insn0,
    input  logic [31:0]          insn1,
    output logic                 br_taken,
    output logic [31:0]          br_target,
    output logic [NGPR*XLEN-1:0] gpr_view,
    output logic [NPRED-1:0]     pred_view
);
    insn_t           ins   [NSLOT];
    slot_res_t       res   [NSLOT];
    logic [GW-1:0]   g_ra  [2*NSLOT];
    logic [XLEN-1:0] g_rv  [2*NSLOT];
    logic            g_we  [NSLOT];
    logic [GW-1:0]   g_wa  [NSLOT];
    logic [XLEN-1:0] g_wd  [NSLOT];
    logic [PW-1:0]   p_ra  [NSLOT];
    logic            p_rv  [NSLOT];
    logic            p_we  [2*NSLOT];
    logic [PW-1:0]   p_wa  [2*NSLOT];
    logic            p_wd  [2*NSLOT];

    assign ins[0] = insn_t'(insn0);
    assign ins[1] = insn_t'(insn1);

    generate
        for (genvar s = 0; s < NSLOT; s++) begin : g_slot
            assign g_ra[2*s]   = ins[s].rs;
            assign g_ra[2*s+1] = ins[s].rt;
            assign p_ra[s]     = ins[s].guard;

            vpx_slot u_slot (
                .clk    (clk),
                .rst    (rst),
                .valid  (bundle_valid),
                .insn   (ins[s]),
                .rs_val (g_rv[2*s]),
                .rt_val (g_rv[2*s+1]),
                .pc     (bundle_pc),
                .guard  (p_rv[s]),
                .res    (res[s])
            );

            assign g_we[s] = res[s].gpr_we;
            assign g_wa[s] = res[s].gpr_wa;
            assign g_wd[s] = res[s].gpr_wd;
            // Inverse first, direct second: direct wins within a slot.
            assign p_we[2*s]   = res[s].pf_we;
            assign p_wa[2*s]   = res[s].pf_wa;
            assign p_wd[2*s]   = !res[s].pval;
            assign p_we[2*s+1] = res[s].pt_we;
            assign p_wa[2*s+1] = res[s].pt_wa;
            assign p_wd[2*s+1] = res[s].pval;
        end
    endgenerate

    vpx_gpr_file u_gpr (
        .clk     (clk),
        .rst     (rst),
        .rd_addr (g_ra),
        .rd_data (g_rv),
        .we      (g_we),
        .wa      (g_wa),
        .wd      (g_wd),
        .view    (gpr_view)
    );

    vpx_pred_file u_pred (
        .clk     (clk),
        .rst     (rst),
        .rd_addr (p_ra),
        .rd_data (p_rv),
        .we      (p_we),
        .wa      (p_wa),
        .wd      (p_wd),
        .view    (pred_view)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            br_taken  <= 1'b0;
            br_target <= '0;
        end else begin
            br_taken  <= res[0].br_take || res[1].br_take;
            br_target <= res[0].br_take ? res[0].br_tgt : res[1].br_tgt;
        end
    end

    p_branch_unguarded_r11: assert property (@(posedge clk) disable iff (rst)
        (bundle_valid && is_branch(ins[0].op) && !p_rv[0] &&
         ((ins[0].op == OP_BEQ) == (g_rv[0] == g_rv[1])))
        |=> br_taken);

    p_idle_no_branch_r12: assert property (@(posedge clk) disable iff (rst)
        !bundle_valid |=> !br_taken);
endmodule

// File: tb/tb_vpx_exec.sv
`timescale 1ns/1ps
module tb_vpx_exec;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bundle_valid = 1'b0;
    logic [31:0]  bundle_pc = '0;
    logic [31:0]  insn0 = '0;
    logic [31:0]  insn1 = '0;
    logic         br_taken;
    logic [31:0]  br_target;
    logic [511:0] gpr_view;
    logic [7:0]   pred_view;

    vpx_exec dut (
        .clk(clk), .rst(rst), .bundle_valid(bundle_valid), .bundle_pc(bundle_pc),
        .insn0(insn0), .insn1(insn1), .br_taken(br_taken), .br_target(br_target),
        .gpr_view(gpr_view), .pred_view(pred_view)
    );

    always #10 clk = ~clk;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    typedef struct {
        logic [511:0] g;
        logic [7:0]   p;
        logic         bt;
        logic [31:0]  btg;
        string        tag;
    } exp_t;
    exp_t q[$];

    logic [31:0] m_g [16];
    logic [7:0]  m_p;

    function automatic logic [31:0] mk(input int op, input int pg, input int rd,
                                       input int rs, input int rt, input int imm);
        return {op[3:0], pg[2:0], rd[3:0], rs[3:0], rt[3:0], imm[12:0]};
    endfunction

    function automatic logic [31:0] sx(input logic [12:0] i);
        return {{19{i[12]}}, i};
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [511:0] act, input logic [511:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Reference model: read old state, collect writes, apply in slot order.
    task automatic drive(input logic v, input logic [31:0] pc,
                         input logic [31:0] a, input logic [31:0] b, input string tag);
        logic [31:0] sl [2];
        logic [31:0] og [16];
        logic [7:0]  op_;
        logic        bt;
        logic [31:0] btg;
        exp_t        e;
        sl[0] = a; sl[1] = b;
        for (int k = 0; k < 16; k++) og[k] = m_g[k];
        op_ = m_p;
        bt = 1'b0; btg = '0;
        for (int s = 0; s < 2; s++) begin
            logic [3:0]  o;
            logic [31:0] x, y, im;
            logic        g, c;
            o  = sl[s][31:28];
            g  = op_[sl[s][27:25]];
            x  = og[sl[s][20:17]];
            y  = og[sl[s][16:13]];
            im = sx(sl[s][12:0]);
            if (v && (o == 12 || o == 13)) begin
                c = (o == 12) ? (x == y) : (x != y);
                if (c && !bt) begin bt = 1'b1; btg = pc + im; end
            end
            if (v && g) begin
                logic        w;
                logic [31:0] r;
                w = 1'b1; r = '0;
                case (o)
                    1: r = x + y;
                    2: r = x - y;
                    3: r = x & y;
                    4: r = x | y;
                    5: r = x ^ y;
                    6: r = x + im;
                    7: begin r = x; w = (y == 0); end
                    8: begin r = x; w = (y != 0); end
                    default: w = 1'b0;
                endcase
                if (w && sl[s][24:21] != 0) m_g[sl[s][24:21]] = r;
                if (o >= 9 && o <= 11) begin
                    if (o == 9)       c = (x == y);
                    else if (o == 10) c = ($signed(x) < $signed(y));
                    else              c = (x < y);
                    if (sl[s][2:0] != 0)   m_p[sl[s][2:0]]   = !c;
                    if (sl[s][23:21] != 0) m_p[sl[s][23:21]] = c;
                end
            end
        end
        bundle_valid = v; bundle_pc = pc; insn0 = a; insn1 = b;
        for (int k = 0; k < 16; k++) e.g[k*32 +: 32] = m_g[k];
        e.p = m_p; e.bt = bt; e.btg = bt ? btg : 32'h0; e.tag = tag;
        @(posedge clk);
        q.push_back(e);
        #2;
    endtask

    // Monitor: compares each expected item after the edge that commits it.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(e.tag, "gpr", gpr_view, e.g);
                check(e.tag, "pred", {504'h0, pred_view}, {504'h0, e.p});
                check(e.tag, "branch", {479'h0, br_taken, (br_taken ? br_target : 32'h0)},
                      {479'h0, e.bt, e.btg});
            end
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        tests++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int k = 0; k < 16; k++) m_g[k] = '0;
        m_p = 8'h01;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        #3;
        // R1: reset state
        check("R1", "gpr", gpr_view, '0);
        check("R1", "pred", {504'h0, pred_view}, {504'h0, 8'h01});
        check("R1", "branch", {511'h0, br_taken}, '0);

        // R2: ALU operations
        drive(1, 32'h100, mk(6,0,1,0,0,5), mk(6,0,2,0,0,-3), "R2");
        drive(1, 32'h104, mk(1,0,3,1,2,0), mk(2,0,4,1,2,0), "R2");
        drive(1, 32'h108, mk(3,0,5,1,2,0), mk(4,0,6,1,2,0), "R2");
        drive(1, 32'h10c, mk(5,0,7,1,2,0), mk(0,0,8,1,2,0), "R2");
        // R3: write to register 0 dropped
        drive(1, 32'h110, mk(6,0,0,1,0,7), mk(1,0,0,1,1,0), "R3");
        // R6/R10/R7: compare sets p1/p2; same-bundle consumer sees old p1=0
        drive(1, 32'h114, mk(10,0,1,2,1,2), mk(6,1,9,0,0,77), "R10");
        // R7: p1 true writes, p2 false nullified (also a compare under false guard)
        drive(1, 32'h118, mk(6,1,10,0,0,100), mk(6,2,11,0,0,200), "R7");
        drive(1, 32'h11c, mk(9,2,3,0,0,4), mk(0,0,0,0,0,0), "R7");
        // R4/R5: zero test register
        drive(1, 32'h120, mk(7,0,12,1,0,0), mk(8,0,13,1,0,0), "R4");
        // R4/R5: non-zero test register
        drive(1, 32'h124, mk(7,0,14,2,1,0), mk(8,0,15,2,1,0), "R5");
        // R6: guard 0 writes ignored, equal pd/pf index -> direct wins, unsigned
        drive(1, 32'h128, mk(9,0,0,1,1,5), mk(11,0,6,1,2,6), "R6");
        drive(1, 32'h12c, mk(11,0,7,2,1,3), mk(0,0,0,0,0,0), "R6");
        // R8: swap r1 and r2
        drive(1, 32'h130, mk(1,0,1,2,0,0), mk(1,0,2,1,0,0), "R8");
        // R9: same destination, slot 1 wins; slot 1 nullified keeps slot 0
        drive(1, 32'h134, mk(6,0,10,0,0,11), mk(6,0,10,0,0,22), "R9");
        drive(1, 32'h138, mk(6,0,11,0,0,33), mk(6,4,11,0,0,44), "R9");
        drive(1, 32'h13c, mk(9,0,4,0,0,5), mk(9,0,5,0,1,4), "R9");
        // R11: branch under false guard still taken; slot1 only; both taken
        drive(1, 32'h200, mk(12,2,0,0,0,-8), mk(0,0,0,0,0,0), "R11");
        drive(1, 32'h210, mk(13,0,0,0,0,16), mk(13,2,0,1,0,40), "R11");
        drive(1, 32'h220, mk(12,0,0,3,3,12), mk(12,0,0,0,0,64), "R11");
        // R12: invalid bundle does nothing
        drive(0, 32'h230, mk(6,0,1,0,0,99), mk(12,0,0,0,0,4), "R12");
        // Mixed random bundles
        for (int n = 0; n < 300; n++) begin
            logic [31:0] a, b;
            a = $urandom; b = $urandom;
            a[31:28] = 4'($urandom % 14); b[31:28] = 4'($urandom % 14);
            a[27:25] = 3'($urandom % 4);  b[27:25] = 3'($urandom % 4);
            drive(($urandom % 8) != 0, $urandom, a, b, "R2");
        end
        drive(0, 0, 0, 0, "R12");
        @(posedge clk); #6;
        if (q.size() != 0) begin
            tests++; fails++;
            $display("FAIL R2 pending items actual %0d expected 0", q.size());
        end
        finish_run();
    end
endmodule